// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This block gathers eleven interrupt sources of a serial port into one raw status register and filters them through a programmable enable mask. It drives six active-high interrupt lines. One line is the OR of every enabled source. The other five each cover a fixed group: receive, transmit, receive timeout, modem status and error. Neighbouring logic detects the events and reports each one as a single-cycle set pulse on its own input bit. Software uses the write port to load the enable mask or to clear raw bits, and the read port to see either the raw or the masked view.

Every output is a flop. Any change to the raw status or to the mask shows on the lines and on the read data one clock after the register that holds it has changed. A raw bit is sticky: once set, it stays set until a clear write removes it.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the raw status, the mask, all six lines and `rd_data_o` are zero.
- R2: A set pulse on source bit k makes raw bit k one from the next clock edge on. It stays one until it is cleared. The edge after that, a raw read (`rd_sel_i` = 0) returns it.
- R3: A write with `wr_sel_i` = 1 (clear) clears each raw bit whose written bit is one. Bits written as zero keep their value.
- R4: If a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: A read with `rd_sel_i` = 1 (masked) returns raw AND mask. A write with `wr_sel_i` = 0 loads the mask from `wr_data_i`.
- R6: `irq_err_o` is high when any masked bit among 7 (framing), 8 (parity), 9 (break) or 10 (overrun) is set.
- R7: `irq_modem_o` is high when any masked bit among 0 (ring), 1 (clear-to-send), 2 (carrier detect) or 3 (data-set-ready) is set.
- R8: `irq_rx_o`, `irq_tx_o` and `irq_rto_o` follow masked bits 4, 5 and 6.
- R9: `irq_any_o` is the OR of all eleven masked bits.
- R10: A mask write shows on the lines and on the masked read one edge after the mask register loads. No other delay is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_set_i | input | 11 | Per-source set pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask, 1 clear |
| wr_data_i | input | 11 | Write data |
| rd_sel_i | input | 1 | Read view: 0 raw, 1 masked |
| rd_data_o | output | 11 | Registered read data |
| irq_any_o | output | 1 | Combined line |
| irq_rx_o | output | 1 | Receive line |
| irq_tx_o | output | 1 | Transmit line |
| irq_rto_o | output | 1 | Receive timeout line |
| irq_modem_o | output | 1 | Modem status line |
| irq_err_o | output | 1 | Error line |

## Verification
The bench builds the block with its default width of eleven sources, so every group boundary is present: the four modem bits, the three single-bit lines and the four error bits. Random set pulses, mask loads and clear writes reach every bit position. Random mask values also cover the cases where a pending source is hidden or revealed on a group line. Directed steps cover set/clear collisions, clears with mixed zero bits, and mask changes with sources pending.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int SRC_W     = 11;
    localparam int NUM_LINES = 6;

    localparam int B_RI  = 0;
    localparam int B_CTS = 1;
    localparam int B_DCD = 2;
    localparam int B_DSR = 3;
    localparam int B_RX  = 4;
    localparam int B_TX  = 5;
    localparam int B_RTO = 6;
    localparam int B_FE  = 7;
    localparam int B_PE  = 8;
    localparam int B_BE  = 9;
    localparam int B_OE  = 10;

    typedef enum logic {WR_MASK = 1'b0, WR_CLEAR = 1'b1} wr_target_e;
    typedef enum logic {RD_RAW = 1'b0, RD_MASKED = 1'b1} rd_view_e;

    localparam int LINE_ANY   = 0;
    localparam int LINE_RX    = 1;
    localparam int LINE_TX    = 2;
    localparam int LINE_RTO   = 3;
    localparam int LINE_MODEM = 4;
    localparam int LINE_ERR   = 5;

    // Which source bits feed each output line
    function automatic logic [SRC_W-1:0] line_group(input int idx);
        logic [SRC_W-1:0] g;
        g = '0;
        unique case (idx)
            LINE_ANY:   g = '1;
            LINE_RX:    g[B_RX]  = 1'b1;
            LINE_TX:    g[B_TX]  = 1'b1;
            LINE_RTO:   g[B_RTO] = 1'b1;
            LINE_MODEM: begin
                g[B_RI] = 1'b1; g[B_CTS] = 1'b1; g[B_DCD] = 1'b1; g[B_DSR] = 1'b1;
            end
            LINE_ERR:   begin
                g[B_FE] = 1'b1; g[B_PE] = 1'b1; g[B_BE] = 1'b1; g[B_OE] = 1'b1;
            end
            default:    g = '0;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/uirq_raw_status.sv
module uirq_raw_status #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] raw_q
);
    logic [W-1:0] raw_d;

    // Set is applied after clear, so it wins on a collision
    always_comb raw_d = (raw_q & ~clr_i) | set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(set_i)) == $past(set_i)));

    p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(clr_i) & ~$past(set_i)) == '0));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((raw_q ^ $past(raw_q)) & ~($past(set_i) | $past(clr_i))) == '0));
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask_q <= '0;
        else if (load_i) mask_q <= data_i;
    end

    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (mask_q == $past(data_i)));

    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(mask_q));
endmodule

// File: rtl/uirq_line_fanout.sv
module uirq_line_fanout
    import uirq_pkg::*;
#(
    parameter int W = SRC_W,
    parameter int L = NUM_LINES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] mask_i,
    input  logic         rd_sel_i,
    output logic [L-1:0] lines_q,
    output logic [W-1:0] rd_q
);
    logic [W-1:0] masked;
    always_comb masked = raw_i & mask_i;

    for (genvar g = 0; g < L; g++) begin : g_line
        localparam logic [W-1:0] GRP = line_group(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lines_q[g] <= 1'b0;
            else        lines_q[g] <= |(masked & GRP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      rd_q <= '0;
        else if (rd_sel_i == RD_MASKED)  rd_q <= masked;
        else                             rd_q <= raw_i;
    end

    p_err_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lines_q[LINE_ERR] ==
                  |($past(raw_i) & $past(mask_i) & 11'h780)));

    p_modem_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lines_q[LINE_MODEM] ==
                  |($past(raw_i) & $past(mask_i) & 11'h00F)));

    p_any_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lines_q[LINE_ANY] == |($past(raw_i) & $past(mask_i))));

    p_any_covers_groups_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|lines_q[L-1:1]) |-> lines_q[LINE_ANY]);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int SRC_BITS = SRC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_BITS-1:0] src_set_i,
    input  logic                wr_en_i,
    input  logic                wr_sel_i,
    input  logic [SRC_BITS-1:0] wr_data_i,
    input  logic                rd_sel_i,
    output logic [SRC_BITS-1:0] rd_data_o,
    output logic                irq_any_o,
    output logic                irq_rx_o,
    output logic                irq_tx_o,
    output logic                irq_rto_o,
    output logic                irq_modem_o,
    output logic                irq_err_o
);
    logic [SRC_BITS-1:0]  raw_q, mask_q, clr_vec;
    logic                 mask_load;
    logic [NUM_LINES-1:0] lines;

    always_comb begin
        mask_load = wr_en_i && (wr_sel_i == WR_MASK);
        clr_vec   = (wr_en_i && (wr_sel_i == WR_CLEAR)) ? wr_data_i : '0;
    end

    uirq_raw_status #(.W(SRC_BITS)) u_raw (
        .clk(clk), .rst_n(rst_n), .set_i(src_set_i), .clr_i(clr_vec), .raw_q(raw_q)
    );

    uirq_mask_reg #(.W(SRC_BITS)) u_mask (
        .clk(clk), .rst_n(rst_n), .load_i(mask_load), .data_i(wr_data_i), .mask_q(mask_q)
    );

    uirq_line_fanout #(.W(SRC_BITS), .L(NUM_LINES)) u_fan (
        .clk(clk), .rst_n(rst_n), .raw_i(raw_q), .mask_i(mask_q),
        .rd_sel_i(rd_sel_i), .lines_q(lines), .rd_q(rd_data_o)
    );

    always_comb begin
        irq_any_o   = lines[LINE_ANY];
        irq_rx_o    = lines[LINE_RX];
        irq_tx_o    = lines[LINE_TX];
        irq_rto_o   = lines[LINE_RTO];
        irq_modem_o = lines[LINE_MODEM];
        irq_err_o   = lines[LINE_ERR];
    end

    p_collision_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_set_i & clr_vec)) |=> ((raw_q & $past(src_set_i & clr_vec)) == $past(src_set_i & clr_vec)));

    p_rx_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_rx_o == ($past(raw_q[B_RX]) & $past(mask_q[B_RX]))));

    p_masked_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel_i |=> (rd_data_o == ($past(raw_q) & $past(mask_q))));
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
    localparam int W = 11;
    localparam time CLK_P = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] src_set = '0;
    logic         wr_en = 1'b0;
    logic         wr_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_sel = 1'b0;
    logic [W-1:0] rd_data;
    logic irq_any, irq_rx, irq_tx, irq_rto, irq_modem, irq_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m_raw = '0;
    logic [W-1:0] m_mask = '0;

    always #(CLK_P/2) clk = ~clk;

    uart_irq_ctrl u_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_set_i(src_set), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
        .rd_data_o(rd_data), .irq_any_o(irq_any), .irq_rx_o(irq_rx),
        .irq_tx_o(irq_tx), .irq_rto_o(irq_rto), .irq_modem_o(irq_modem),
        .irq_err_o(irq_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected line vector: {err, modem, rto, tx, rx, any}
    function automatic logic [5:0] exp_lines(input logic [W-1:0] r, input logic [W-1:0] m);
        logic [W-1:0] v;
        v = r & m;
        return {|v[10:7], |v[3:0], v[6], v[5], v[4], |v};
    endfunction

    task automatic step(input logic [W-1:0] set, input logic wen, input logic wsel,
                        input logic [W-1:0] wdat, input logic rsel, input string rtag);
        logic [5:0]   el;
        logic [W-1:0] er;
        el = exp_lines(m_raw, m_mask);
        er = rsel ? (m_raw & m_mask) : m_raw;
        src_set = set; wr_en = wen; wr_sel = wsel; wr_data = wdat; rd_sel = rsel;
        if (wen && !wsel) m_mask = wdat;
        m_raw = (m_raw & ~((wen && wsel) ? wdat : '0)) | set;
        @(posedge clk);
        #1;
        check("R9 any",   irq_any,   el[0]);
        check("R8 rx",    irq_rx,    el[1]);
        check("R8 tx",    irq_tx,    el[2]);
        check("R8 rto",   irq_rto,   el[3]);
        check("R7 modem", irq_modem, el[4]);
        check("R6 err",   irq_err,   el[5]);
        check(rtag, rd_data, er);
        @(negedge clk);
    endtask

    bit done = 0;

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 rd", rd_data, 0);
        check("R1 lines", {irq_err, irq_modem, irq_rto, irq_tx, irq_rx, irq_any}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        step('0, 0, 0, '0, 0, "R1 raw");
        step('0, 0, 0, '0, 1, "R1 masked");
        // R2: set bit 4, then read raw; it sticks
        step(11'h010, 0, 0, '0, 0, "R2 raw");
        step('0, 0, 0, '0, 0, "R2 raw");
        step('0, 0, 0, '0, 0, "R2 sticky");
        // R10: enable all, masked read and lines follow next edge
        step('0, 1, 0, 11'h7FF, 1, "R10 masked");
        step('0, 0, 0, '0, 1, "R10 masked");
        // R3: clear with mixed bits
        step(11'h481, 0, 0, '0, 0, "R3 raw");
        step('0, 1, 1, 11'h011, 0, "R3 raw");
        step('0, 0, 0, '0, 0, "R3 partial clear");
        // R4: collision on bit 10
        step(11'h400, 1, 1, 11'h7FF, 0, "R4 raw");
        step('0, 0, 0, '0, 0, "R4 set wins");
        // R5: narrow mask hides modem bits
        step(11'h00F, 1, 0, 11'h780, 1, "R5 masked");
        step('0, 0, 0, '0, 1, "R5 masked");

        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] s, d;
            logic we, ws, rs;
            s  = W'($urandom & $urandom & $urandom);
            we = ($urandom % 4) == 0;
            ws = $urandom % 2;
            d  = W'($urandom);
            rs = $urandom % 2;
            step(s, we, ws, d, rs, rs ? "R5 masked rand" : "R2 R3 raw rand");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule